// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a serial-peripheral slave (SPI mode 0, most significant bit first) that lets a host read and write a 128-entry byte register space. The space holds three kinds of location: general read/write byte registers, a set of 16-bit data-register pairs that connect to a bus-side transmitter and receiver, and a reserved window. A frame opens when chip select falls. It carries a command byte whose top bit selects write (1) or read (0) and whose low seven bits give a start address. One or three data bytes follow, and each of them touches the next sequential address.

All serial inputs are brought into the system clock domain through synchronizers. The frame's clock count is checked when chip select rises. Only 16-clock and 32-clock frames take effect. Write data waits in a shadow buffer until that check passes, so a truncated or overlong frame leaves every register and flag untouched. Each data-register pair has two handshake flags. The transmit-empty flag tells the host whether the bus side has consumed the last word written. The receive-full flag tells the host that the bus side has deposited a word that has not yet been read.

Top module: `spi_regfile_slave`

## Requirements
- R1: A frame starts when cs_n falls. MOSI is sampled on each rising SCLK edge, most significant bit first. In the first byte, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6..0 give the start address.
- R2: A frame changes nothing unless it holds exactly 16 or 32 SCLK rising edges. Other frames leave the general registers, tx_data, tx_empty and rx_full unchanged.
- R3: General registers occupy addresses 0x08..0x6F and reset to 0x00. A byte written in a legal frame reads back unchanged in later frames.
- R4: A 32-clock frame carries three data bytes, which go to the start address, start+1 and start+2, in that order.
- R5: MISO is 0 for the whole command byte. Each following byte returns the register at the matching address, MSB first, valid at the rising SCLK edge. Writes in a frame are not visible to reads within the same frame.
- R6: Addresses 0x70..0x7F are reserved. Writes to them are ignored and reads return 0x00.
- R7: Pair k sits at address 2k (high byte, word bits 15:8) and 2k+1 (low byte, bits 7:0). A write updates that byte of tx_data[16k+15:16k]. A read returns the word last captured from rx_data for pair k.
- R8: tx_empty[k] resets to 1. It clears after a legal frame that writes either byte of pair k, and sets again on a tx_sent[k] pulse.
- R9: rx_full[k] resets to 0. An rx_load[k] pulse sets it and captures rx_data[16k+15:16k]. It clears after a legal read frame that reads either byte of pair k.
- R10: During a burst, the address wraps from 0x7F to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 outside data bytes |
| tx_data | output | NUM_PAIRS*16 | Transmit word of every pair |
| tx_sent | input | NUM_PAIRS | Pulse: bus side has sent the pair's word |
| rx_load | input | NUM_PAIRS | Pulse: bus side deposits rx_data into the pair |
| rx_data | input | NUM_PAIRS*16 | Receive words from the bus side |
| tx_empty | output | NUM_PAIRS | Transmit-empty flag per pair |
| rx_full | output | NUM_PAIRS | Receive-full flag per pair |

## Verification
A wrong bit counter or framing decision shows up when chip select rises. In that cycle an illegal frame alters a register, tx_data or a flag, or a legal frame fails to. Either error is visible on the next read frame or on the flag ports a few clocks later. A stale address cursor or a prefetch from the wrong location corrupts the MISO byte that follows in the same frame. The bench compares every returned byte and all flags after each frame, so such faults appear within one frame.

// File: rtl/spi_regfile_pkg.sv
// Shared constants, types and address classification for the serial
// register access slave. Assumes a 7-bit address space of byte registers.
package spi_regfile_pkg;

    localparam int ADDR_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int REG_COUNT  = 1 << ADDR_W;
    localparam int SHORT_BITS = 2 * BYTE_W;
    localparam int LONG_BITS  = 4 * BYTE_W;
    localparam int MAX_DATA   = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        AREA_GEN  = 2'd0,
        AREA_PAIR = 2'd1,
        AREA_RSVD = 2'd2
    } area_e;

    // Decide which storage an address maps to.
    function automatic area_e classify(addr_t a, int pairs, int rsvd_base);
        if (int'(a) >= rsvd_base)
            return AREA_RSVD;
        else if (int'(a) < 2 * pairs)
            return AREA_PAIR;
        else
            return AREA_GEN;
    endfunction

    // Index of the data-register pair that holds an address.
    function automatic int pair_of(addr_t a);
        return int'(a) >> 1;
    endfunction

endpackage

// File: rtl/spi_regfile_sync.sv
// Brings SCLK, cs_n and MOSI into the clk domain through STAGES flops each
// and produces single-cycle edge strobes. Assumes every serial level is held
// for more than STAGES+2 clk cycles.
module spi_regfile_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] RST_VAL = 3'b010;   // {mosi, cs_n, sclk}

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sclk_d;
    logic            cs_d;

    assign raw = {mosi, cs_n, sclk};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [STAGES-1:0] chain;
        // Shift the raw level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain <= {STAGES{RST_VAL[g]}};
            else
                chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= synced[0];
            cs_d   <= synced[1];
        end
    end

    assign sclk_rise = synced[0] & ~sclk_d;
    assign sclk_fall = ~synced[0] & sclk_d;
    assign cs_fall   = ~synced[1] & cs_d;
    assign cs_rise   = synced[1] & ~cs_d;
    assign mosi_s    = synced[2];

endmodule

// File: rtl/spi_regfile_shifter.sv
// Frame engine: counts rising SCLK edges while selected, assembles bytes,
// shifts read data out on falling edges and judges frame length when
// chip select rises. Assumes rd_byte is valid one cycle after byte_done
// and that the next falling edge comes later than that.
module spi_regfile_shifter
    import spi_regfile_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       cs_fall,
    input  logic       cs_rise,
    input  logic       mosi_s,
    input  byte_t      rd_byte,
    output logic       miso,
    output logic       in_frame,
    output logic       byte_done,
    output logic [1:0] byte_idx,
    output byte_t      byte_val,
    output logic       frame_end,
    output logic       frame_ok
);
    localparam int CNT_SAT   = LONG_BITS + 1;
    localparam int CNT_W     = $clog2(CNT_SAT + 1);
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_sh;
    byte_t            tx_sh;
    logic             load_q;
    logic             byte_last;

    assign byte_last = (bit_cnt[BIT_IDX_W-1:0] == BIT_IDX_W'(BYTE_W - 1))
                       && (bit_cnt < CNT_W'(LONG_BITS));

    // Track the frame, shift bits in and out, and judge its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            miso      <= 1'b0;
            byte_done <= 1'b0;
            byte_idx  <= '0;
            byte_val  <= '0;
            frame_end <= 1'b0;
            frame_ok  <= 1'b0;
            load_q    <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            frame_end <= 1'b0;
            load_q    <= byte_done;
            if (cs_fall) begin
                in_frame <= 1'b1;
                bit_cnt  <= '0;
                rx_sh    <= '0;
                tx_sh    <= '0;
                miso     <= 1'b0;
            end else if (cs_rise) begin
                in_frame <= 1'b0;
                miso     <= 1'b0;
                if (in_frame) begin
                    frame_end <= 1'b1;
                    frame_ok  <= (bit_cnt == CNT_W'(SHORT_BITS)) ||
                                 (bit_cnt == CNT_W'(LONG_BITS));
                end
            end else if (in_frame) begin
                if (sclk_rise) begin
                    rx_sh <= {rx_sh[BYTE_W-2:0], mosi_s};
                    if (bit_cnt != CNT_W'(CNT_SAT))
                        bit_cnt <= bit_cnt + 1'b1;
                    if (byte_last) begin
                        byte_done <= 1'b1;
                        byte_idx  <= bit_cnt[BIT_IDX_W +: 2];
                        byte_val  <= {rx_sh[BYTE_W-2:0], mosi_s};
                    end
                end
                if (sclk_fall) begin
                    miso  <= tx_sh[BYTE_W-1];
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
                if (load_q)
                    tx_sh <= rd_byte;
            end
        end
    end

    AST_CMD_BYTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (in_frame && bit_cnt < CNT_W'(BYTE_W)) |-> !miso); // R5

endmodule

// File: rtl/spi_regfile_bank.sv
// Register storage: general bytes, transmit/receive pairs with handshake
// flags, and the shadow buffer that defers writes until a legal frame
// closes. Assumes byte_done and frame_end never coincide.
module spi_regfile_bank
    import spi_regfile_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int RSVD_BASE = 112
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_done,
    input  logic [1:0]                  byte_idx,
    input  byte_t                       byte_val,
    input  logic                        frame_end,
    input  logic                        frame_ok,
    input  logic [NUM_PAIRS-1:0]        tx_sent,
    input  logic [NUM_PAIRS-1:0]        rx_load,
    input  logic [NUM_PAIRS*WORD_W-1:0] rx_data,
    output byte_t                       rd_byte,
    output logic [NUM_PAIRS*WORD_W-1:0] tx_data,
    output logic [NUM_PAIRS-1:0]        tx_empty,
    output logic [NUM_PAIRS-1:0]        rx_full
);
    byte_t                       mem [REG_COUNT];
    logic [NUM_PAIRS*WORD_W-1:0] tx_flat;
    logic [NUM_PAIRS*WORD_W-1:0] rx_flat;
    logic                        cmd_wr;
    addr_t                       cur_addr;
    byte_t                       sh_data [MAX_DATA];
    addr_t                       sh_addr [MAX_DATA];
    logic [MAX_DATA-1:0]         sh_vld;
    logic [NUM_PAIRS-1:0]        wr_pend;
    logic [NUM_PAIRS-1:0]        rd_pend;
    logic                        commit;
    area_e                       cur_area;

    assign commit   = frame_end && frame_ok;
    assign cur_area = classify(cur_addr, NUM_PAIRS, RSVD_BASE);
    assign tx_data  = tx_flat;

    // Latch the command, advance the cursor and stage write bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_wr   <= 1'b0;
            cur_addr <= '0;
            sh_vld   <= '0;
            wr_pend  <= '0;
            rd_pend  <= '0;
            for (int j = 0; j < MAX_DATA; j++) begin
                sh_data[j] <= '0;
                sh_addr[j] <= '0;
            end
        end else if (frame_end) begin
            sh_vld  <= '0;
            wr_pend <= '0;
            rd_pend <= '0;
        end else if (byte_done) begin
            if (byte_idx == 2'd0) begin
                cmd_wr   <= byte_val[BYTE_W-1];
                cur_addr <= byte_val[ADDR_W-1:0];
            end else begin
                cur_addr <= cur_addr + 1'b1;
                if (cmd_wr) begin
                    sh_data[byte_idx - 2'd1] <= byte_val;
                    sh_addr[byte_idx - 2'd1] <= cur_addr;
                    sh_vld[byte_idx - 2'd1]  <= 1'b1;
                    if (cur_area == AREA_PAIR)
                        wr_pend[pair_of(cur_addr)] <= 1'b1;
                end else if (cur_area == AREA_PAIR) begin
                    rd_pend[pair_of(cur_addr)] <= 1'b1;
                end
            end
        end
    end

    // Commit staged bytes to general registers or transmit words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++)
                mem[i] <= '0;
            tx_flat <= '0;
        end else if (commit) begin
            for (int j = 0; j < MAX_DATA; j++) begin
                if (sh_vld[j]) begin
                    case (classify(sh_addr[j], NUM_PAIRS, RSVD_BASE))
                        AREA_GEN:  mem[sh_addr[j]] <= sh_data[j];
                        AREA_PAIR: tx_flat[pair_of(sh_addr[j]) * WORD_W
                                           + (sh_addr[j][0] ? 0 : BYTE_W) +: BYTE_W]
                                       <= sh_data[j];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Capture receive words and update both handshake flags per pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flat  <= '0;
            tx_empty <= '1;
            rx_full  <= '0;
        end else begin
            for (int k = 0; k < NUM_PAIRS; k++) begin
                if (rx_load[k])
                    rx_flat[k*WORD_W +: WORD_W] <= rx_data[k*WORD_W +: WORD_W];
                // a fresh host write outranks a send report
                if (commit && wr_pend[k])
                    tx_empty[k] <= 1'b0;
                else if (tx_sent[k])
                    tx_empty[k] <= 1'b1;
                // a fresh deposit outranks a host read
                if (rx_load[k])
                    rx_full[k] <= 1'b1;
                else if (commit && rd_pend[k])
                    rx_full[k] <= 1'b0;
            end
        end
    end

    // Return the byte at the cursor for the next outgoing data byte.
    always_comb begin
        case (cur_area)
            AREA_GEN:  rd_byte = mem[cur_addr];
            AREA_PAIR: rd_byte = rx_flat[pair_of(cur_addr) * WORD_W
                                         + (cur_addr[0] ? 0 : BYTE_W) +: BYTE_W];
            default:   rd_byte = '0;
        endcase
    end

    AST_COMMIT_BYTES: assert property (@(posedge clk) disable iff (!rst_n) (commit && cmd_wr) |-> ($countones(sh_vld) == 1 || $countones(sh_vld) == MAX_DATA)); // R4

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_flag_chk
        AST_TX_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (commit && wr_pend[k]) |=> !tx_empty[k]); // R8
        AST_TX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n) (tx_sent[k] && !(commit && wr_pend[k])) |=> tx_empty[k]); // R8
        AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_load[k] |=> rx_full[k]); // R9
        AST_RX_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (commit && rd_pend[k] && !rx_load[k]) |=> !rx_full[k]); // R9
    end

endmodule

// File: rtl/spi_regfile_slave.sv
// Top level of the serial register access slave: synchronizer, frame
// engine and register bank. Assumes SCLK half periods of at least
// SYNC_STAGES+4 clk cycles and SCLK low whenever cs_n changes.
module spi_regfile_slave
    import spi_regfile_pkg::*;
#(
    parameter int NUM_PAIRS   = 4,
    parameter int RSVD_BASE   = 112,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sclk,
    input  logic                        cs_n,
    input  logic                        mosi,
    output logic                        miso,
    output logic [NUM_PAIRS*WORD_W-1:0] tx_data,
    input  logic [NUM_PAIRS-1:0]        tx_sent,
    input  logic [NUM_PAIRS-1:0]        rx_load,
    input  logic [NUM_PAIRS*WORD_W-1:0] rx_data,
    output logic [NUM_PAIRS-1:0]        tx_empty,
    output logic [NUM_PAIRS-1:0]        rx_full
);
    logic       sclk_rise;
    logic       sclk_fall;
    logic       cs_fall;
    logic       cs_rise;
    logic       mosi_s;
    logic       in_frame;
    logic       byte_done;
    logic [1:0] byte_idx;
    byte_t      byte_val;
    logic       frame_end;
    logic       frame_ok;
    byte_t      rd_byte;

    spi_regfile_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .mosi_s    (mosi_s)
    );

    spi_regfile_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .mosi_s    (mosi_s),
        .rd_byte   (rd_byte),
        .miso      (miso),
        .in_frame  (in_frame),
        .byte_done (byte_done),
        .byte_idx  (byte_idx),
        .byte_val  (byte_val),
        .frame_end (frame_end),
        .frame_ok  (frame_ok)
    );

    spi_regfile_bank #(.NUM_PAIRS(NUM_PAIRS), .RSVD_BASE(RSVD_BASE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .byte_idx  (byte_idx),
        .byte_val  (byte_val),
        .frame_end (frame_end),
        .frame_ok  (frame_ok),
        .tx_sent   (tx_sent),
        .rx_load   (rx_load),
        .rx_data   (rx_data),
        .rd_byte   (rd_byte),
        .tx_data   (tx_data),
        .tx_empty  (tx_empty),
        .rx_full   (rx_full)
    );

    AST_NO_BYTE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !in_frame |-> !byte_done); // R1

endmodule

// File: tb/tb_spi_regfile_slave.sv
`timescale 1ns/1ps
module tb_spi_regfile_slave;
    localparam int NP   = 4;
    localparam int HALF = 8;
    localparam int RSVD = 112;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            sclk, cs_n, mosi;
    logic            miso;
    logic [NP*16-1:0] tx_data;
    logic [NP-1:0]   tx_sent, rx_load;
    logic [NP*16-1:0] rx_data;
    logic [NP-1:0]   tx_empty, rx_full;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0]  ref_mem [128];
    logic [15:0] ref_tx [NP];
    logic [15:0] ref_rx [NP];
    logic        ref_te [NP];
    logic        ref_rne [NP];

    always #2.5 clk = ~clk;

    spi_regfile_slave #(.NUM_PAIRS(NP), .RSVD_BASE(RSVD)) dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .tx_data(tx_data), .tx_sent(tx_sent), .rx_load(rx_load),
        .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full)
    );

    // 0 general, 1 pair, 2 reserved
    function automatic int area(int a);
        if (a >= RSVD) return 2;
        if (a < 2 * NP) return 1;
        return 0;
    endfunction

    function automatic logic [7:0] ref_read(int a);
        case (area(a))
            0: return ref_mem[a];
            1: return (a % 2 == 0) ? ref_rx[a/2][15:8] : ref_rx[a/2][7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        for (int k = 0; k < NP; k++) begin
            chk({31'd0, tx_empty[k]}, {31'd0, ref_te[k]}, {tag, " R8 tx_empty"});
            chk({31'd0, rx_full[k]}, {31'd0, ref_rne[k]}, {tag, " R9 rx_full"});
            chk({16'd0, tx_data[k*16 +: 16]}, {16'd0, ref_tx[k]}, {tag, " R7 tx_data"});
        end
    endtask

    task automatic spi_frame(input int nbits, input logic [31:0] w, output logic [31:0] r);
        r = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? w[31-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 32) r[31-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // One frame with full model update and checks of MISO and flags.
    task automatic frame_op(input int nbits, input logic wr, input int a,
                            input logic [23:0] data, input string tag);
        logic [31:0] w, r, exp;
        int nb;
        w   = {wr, 7'(a), data};
        exp = {8'h00, ref_read(a % 128), ref_read((a+1) % 128), ref_read((a+2) % 128)};
        spi_frame(nbits, w, r);
        if (nbits == 16)
            chk({16'd0, r[31:16]}, {16'd0, exp[31:16]}, {tag, " R5 miso"});
        else if (nbits == 32)
            chk(r, exp, {tag, " R5 miso"});
        if (nbits == 16 || nbits == 32) begin
            nb = (nbits == 32) ? 3 : 1;
            for (int j = 0; j < nb; j++) begin
                int ad;
                logic [7:0] d;
                ad = (a + j) % 128;
                d  = data[23-8*j -: 8];
                if (wr) begin
                    if (area(ad) == 0) ref_mem[ad] = d;
                    else if (area(ad) == 1) begin
                        if (ad % 2 == 0) ref_tx[ad/2][15:8] = d;
                        else             ref_tx[ad/2][7:0]  = d;
                        ref_te[ad/2] = 1'b0;
                    end
                end else if (area(ad) == 1) begin
                    ref_rne[ad/2] = 1'b0;
                end
            end
        end
        chk_flags(tag);
    endtask

    task automatic pulse_sent(input int k);
        @(negedge clk); tx_sent[k] = 1'b1;
        @(negedge clk); tx_sent[k] = 1'b0;
        ref_te[k] = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_load(input int k, input logic [15:0] d);
        @(negedge clk); rx_data[k*16 +: 16] = d; rx_load[k] = 1'b1;
        @(negedge clk); rx_load[k] = 1'b0;
        ref_rx[k] = d; ref_rne[k] = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int bad_len [7] = '{8, 15, 17, 24, 31, 33, 40};
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h00;
        for (int k = 0; k < NP; k++) begin
            ref_tx[k] = '0; ref_rx[k] = '0; ref_te[k] = 1'b1; ref_rne[k] = 1'b0;
        end
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        tx_sent = '0; rx_load = '0; rx_data = '0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk({31'd0, miso}, 32'd0, "reset R5 miso");
        chk_flags("reset");

        // R1/R3: single write then read back
        frame_op(16, 1'b1, 8'h10, 24'hA5_0000, "R1 R3 write");
        frame_op(16, 1'b0, 8'h10, 24'h0, "R3 readback");

        // R4: burst write and burst read
        frame_op(32, 1'b1, 8'h20, 24'hAABBCC, "R4 burst write");
        frame_op(32, 1'b0, 8'h20, 24'h0, "R4 burst read");

        // R2: illegal lengths change nothing, including pair flags
        for (int i = 0; i < 7; i++) begin
            frame_op(bad_len[i], 1'b1, 8'h20, 24'h112233, "R2 bad length");
            frame_op(bad_len[i], 1'b1, 8'h00, 24'h445566, "R2 bad length pair");
        end
        frame_op(32, 1'b0, 8'h20, 24'h0, "R2 readback");

        // R6: reserved window
        frame_op(16, 1'b1, 8'h75, 24'h5A_0000, "R6 reserved write");
        frame_op(16, 1'b0, 8'h75, 24'h0, "R6 reserved read");

        // R7/R8: transmit word and transmit-empty handshake
        frame_op(16, 1'b1, 8'h02, 24'h12_0000, "R7 pair1 hi");
        frame_op(16, 1'b1, 8'h03, 24'h34_0000, "R7 pair1 lo");
        pulse_sent(1);
        chk_flags("R8 after send");

        // R9: receive word and receive-full handshake
        pulse_load(2, 16'hBEEF);
        chk_flags("R9 after load");
        frame_op(24, 1'b0, 8'h04, 24'h0, "R9 bad-length read");
        frame_op(16, 1'b0, 8'h05, 24'h0, "R9 read lo");

        // R10: address wrap
        frame_op(32, 1'b1, 8'h7F, 24'h01C3D4, "R10 wrap write");
        pulse_load(0, 16'h6E9A);
        frame_op(32, 1'b0, 8'h7F, 24'h0, "R10 wrap read");

        // R1: constrained random mix
        for (int n = 0; n < 80; n++) begin
            int op, a;
            op = $urandom_range(0, 5);
            a  = $urandom_range(0, 127);
            case (op)
                0: frame_op(16, 1'b1, a, 24'($urandom), "R1 random w16");
                1: frame_op(32, 1'b1, a, 24'($urandom), "R1 random w32");
                2: frame_op(16, 1'b0, a, 24'h0, "R1 random r16");
                3: frame_op(32, 1'b0, a, 24'h0, "R1 random r32");
                4: pulse_load($urandom_range(0, NP-1), 16'($urandom));
                default: pulse_sent($urandom_range(0, NP-1));
            endcase
        end
        chk_flags("R1 random end");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule